// File: doc/BRIEF.md
# Multi-Channel Serial Controller Register Decoder and Interrupt Combiner

This block sits behind one 4 KB peripheral region on an APB bus and serves fourteen serial-bus channel register windows plus one global window. It decodes every access to the correct 64-byte window. The channel windows come in two groups on either side of a buffer-pool hole. The block answers in the access phase with no wait states. Each channel is a stub register set: an interrupt enable, a pending status, a command word and a byte buffer. A command write injects event bits into the channel status, and the enable mask filters them.

The block keeps one global pending bit per channel. A command write that leaves a non-zero masked status sets that channel's bit. Any write to the channel's status register clears it. The single shared interrupt line is high while any global bit is set. Software reads the global status word to find the channels that need service. It then writes each channel's status register to acknowledge it.

Top module: `i2cagg_top`

## Requirements
- R1: After reset the global status word reads 0, `irqOut` is low, and every channel's enable, status, command and buffer registers read 0.
- R2: Channel i for i in 0..6 occupies addresses 0x40*(i+1) to 0x40*(i+1)+0x3F.
- R3: Channel i for i in 7..13 occupies addresses 0x40*(i+5) to 0x40*(i+5)+0x3F. No channel responds in 0x200 to 0x2FF.
- R4: Global offset 0x000 reads the status word, with bit i (i = 0..13) set when channel i is pending and bits 31:14 zero.
- R5: A write to a channel's command register (window offset 0x14) sets its status (offset 0x10, bits 14:0) to (old status OR write bits 14:0) AND the enable register (offset 0x0C, bits 14:0). If the result is non-zero, the channel's global bit is set.
- R6: `irqOut` is high exactly when at least one global pending bit is set.
- R7: Any write to a channel's status register clears the bits of the status that are 1 in the write data, and clears that channel's global bit, even if some status bits remain set.
- R8: Writes anywhere in the global window 0x000 to 0x03F change nothing.
- R9: Reads return 0xFFFFFFFF at unmapped addresses: global offsets other than 0x000, channel window offsets other than 0x0C, 0x10, 0x14 and 0x20, and addresses 0x4C0 to 0x7FF.
- R10: Buffer-pool addresses 0x200 to 0x2FF and 0x800 to 0xFFF read 0 and ignore writes.
- R11: `apbReady` is always 1 and `apbSlvErr` is always 0. Read data is valid in the access phase.
- R12: The enable register holds 15 bits, the command register holds 16 bits and the buffer register (offset 0x20) holds 8 bits. Each reads back its stored value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| apbSel | input | 1 | APB select |
| apbEnable | input | 1 | APB access phase |
| apbWrite | input | 1 | 1 = write, 0 = read |
| apbAddr | input | 12 | Byte address within the region |
| apbWdata | input | 32 | Write data |
| apbRdata | output | 32 | Read data |
| apbReady | output | 1 | Always ready |
| apbSlvErr | output | 1 | Always 0 |
| irqOut | output | 1 | Shared interrupt, high while any channel is pending |

## Verification
The two functions that can meet in one cycle are the acknowledge of one channel and the pending state of another. A status write that clears one channel's global bit must leave another channel's bit and the shared line untouched. The bench raises channels 2 and 9 and then acknowledges channel 2 alone. It then checks that the line stays high and that the global word reads exactly bit 9. It then checks that acknowledging channel 9 with zero data drops both its global bit and the line, while that channel's status keeps its bits.

// File: rtl/i2cagg_pkg.sv
package i2cagg_pkg;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int NUM_CH      = 14;
  localparam int LOW_CH      = 7;
  localparam int WIN_LOG     = 6;
  localparam int HOLE_WIN    = 4;
  localparam int POOL_HI_WIN = 32;
  localparam int STAT_W      = 15;
  localparam int CMD_W       = 16;
  localparam int BUF_W       = 8;

  localparam int WIN_W    = ADDR_W - WIN_LOG;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int HI_BASE  = LOW_CH + 1 + HOLE_WIN;
  localparam int HI_END   = HI_BASE + NUM_CH - LOW_CH;

  localparam logic [WIN_LOG-1:0] OFF_IEN  = 6'h0C;
  localparam logic [WIN_LOG-1:0] OFF_STAT = 6'h10;
  localparam logic [WIN_LOG-1:0] OFF_CMD  = 6'h14;
  localparam logic [WIN_LOG-1:0] OFF_BUF  = 6'h20;

  typedef enum logic [1:0] {AREA_UNMAP, AREA_GLOBAL, AREA_CHAN, AREA_POOL} area_e;
  typedef enum logic [2:0] {REG_NONE, REG_IEN, REG_STAT, REG_CMD, REG_BUF} regSel_e;

  typedef struct packed {
    logic                wr;
    logic                rd;
    area_e               area;
    regSel_e             regSel;
    logic                gStatSel;
    logic [NUM_CH-1:0]   chSel;
    logic [CH_IDX_W-1:0] chIdx;
  } strobe_t;
endpackage

// File: rtl/i2cagg_ctrl.sv
module i2cagg_ctrl
  import i2cagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  output strobe_t           strb
);
  localparam logic [WIN_W-1:0] WinLowEnd  = WIN_W'(LOW_CH);
  localparam logic [WIN_W-1:0] WinHoleEnd = WIN_W'(HI_BASE - 1);
  localparam logic [WIN_W-1:0] WinHiBase  = WIN_W'(HI_BASE);
  localparam logic [WIN_W-1:0] WinHiEnd   = WIN_W'(HI_END - 1);
  localparam logic [WIN_W-1:0] WinPoolHi  = WIN_W'(POOL_HI_WIN);
  localparam logic [WIN_W-1:0] HiShift    = WIN_W'(HI_BASE - LOW_CH);

  logic [WIN_W-1:0]   win;
  logic [WIN_LOG-1:0] off;
  logic               access;

  assign win    = apbAddr[ADDR_W-1:WIN_LOG];
  assign off    = apbAddr[WIN_LOG-1:0];
  assign access = apbSel & apbEnable;

  always_comb begin
    strb.wr       = access & apbWrite;
    strb.rd       = access & ~apbWrite;
    strb.area     = AREA_UNMAP;
    strb.chIdx    = '0;
    strb.gStatSel = (off == '0);
    if (win == '0) begin
      strb.area = AREA_GLOBAL;
    end else if (win <= WinLowEnd) begin
      strb.area  = AREA_CHAN;
      strb.chIdx = CH_IDX_W'(win - WIN_W'(1));
    end else if (win <= WinHoleEnd) begin
      strb.area = AREA_POOL;
    end else if (win >= WinHiBase && win <= WinHiEnd) begin
      strb.area  = AREA_CHAN;
      strb.chIdx = CH_IDX_W'(win - HiShift);
    end else if (win >= WinPoolHi) begin
      strb.area = AREA_POOL;
    end
    case (off)
      OFF_IEN:  strb.regSel = REG_IEN;
      OFF_STAT: strb.regSel = REG_STAT;
      OFF_CMD:  strb.regSel = REG_CMD;
      OFF_BUF:  strb.regSel = REG_BUF;
      default:  strb.regSel = REG_NONE;
    endcase
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign strb.chSel[i] = (strb.area == AREA_CHAN) && (strb.chIdx == CH_IDX_W'(i));
  end

  // R3: no channel window may answer inside the low buffer-pool hole
  p_hole_skip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (access && apbAddr >= 12'h200 && apbAddr < 12'h300) |-> (strb.chSel == '0));
endmodule

// File: rtl/i2cagg_dp.sv
module i2cagg_dp
  import i2cagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] gStat,
  output logic              irqOut
);
  logic [DATA_W-1:0] chRd [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [STAT_W-1:0] ienQ, statQ, raised;
    logic [CMD_W-1:0]  cmdQ;
    logic [BUF_W-1:0]  bufQ;
    logic              gBitQ;
    logic              wrHere;

    assign wrHere = strb.wr & strb.chSel[i];
    assign raised = (statQ | apbWdata[STAT_W-1:0]) & ienQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ienQ  <= '0;
        statQ <= '0;
        cmdQ  <= '0;
        bufQ  <= '0;
        gBitQ <= 1'b0;
      end else if (wrHere) begin
        case (strb.regSel)
          REG_IEN:  ienQ <= apbWdata[STAT_W-1:0];
          REG_STAT: begin
            statQ <= statQ & ~apbWdata[STAT_W-1:0];
            gBitQ <= 1'b0;
          end
          REG_CMD: begin
            cmdQ  <= apbWdata[CMD_W-1:0];
            statQ <= raised;
            if (raised != '0) gBitQ <= 1'b1;
          end
          REG_BUF:  bufQ <= apbWdata[BUF_W-1:0];
          default:  ;
        endcase
      end
    end

    always_comb begin
      case (strb.regSel)
        REG_IEN:  chRd[i] = DATA_W'(ienQ);
        REG_STAT: chRd[i] = DATA_W'(statQ);
        REG_CMD:  chRd[i] = DATA_W'(cmdQ);
        REG_BUF:  chRd[i] = DATA_W'(bufQ);
        default:  chRd[i] = '1;
      endcase
    end

    assign gStat[i] = gBitQ;

    // R7: a status write always drops this channel's pending bit
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wrHere && strb.regSel == REG_STAT) |=> !gStat[i]);
    // R5: a command write with unmasked events pends the channel
    p_raise_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
      (wrHere && strb.regSel == REG_CMD && (apbWdata[STAT_W-1:0] & ienQ) != '0) |=> gStat[i]);
  end

  always_comb begin
    case (strb.area)
      AREA_GLOBAL: rdData = strb.gStatSel ? DATA_W'(gStat) : '1;
      AREA_CHAN:   rdData = chRd[strb.chIdx];
      AREA_POOL:   rdData = '0;
      default:     rdData = '1;
    endcase
  end

  assign irqOut = |gStat;

  // R8: global window writes leave pending state alone
  p_global_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.area == AREA_GLOBAL) |=> $stable(gStat));
  // R6: the line only falls after a channel acknowledge
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(strb.wr && strb.area == AREA_CHAN && strb.regSel == REG_STAT));
endmodule

// File: rtl/i2cagg_top.sv
module i2cagg_top
  import i2cagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] apbRdata,
  output logic              apbReady,
  output logic              apbSlvErr,
  output logic              irqOut
);
  strobe_t           strb;
  logic [NUM_CH-1:0] gStat;

  i2cagg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbAddr(apbAddr), .strb(strb)
  );

  i2cagg_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .apbWdata(apbWdata),
    .rdData(apbRdata), .gStat(gStat), .irqOut(irqOut)
  );

  assign apbReady  = 1'b1;
  assign apbSlvErr = 1'b0;

  // R10: buffer-pool reads return zero
  p_pool_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.area == AREA_POOL) |-> (apbRdata == '0));
  // R9: unmapped reads return all ones
  p_unmap_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.area == AREA_UNMAP) |-> (apbRdata == '1));
endmodule

// File: tb/i2cagg_top_tb_top.sv
`timescale 1ns/1ps
module i2cagg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        apbSel = 1'b0, apbEnable = 1'b0, apbWrite = 1'b0;
  logic [11:0] apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic [31:0] apbRdata;
  logic        apbReady, apbSlvErr, irqOut;

  int total = 0;
  int bad = 0;
  int          addrQ[$];
  logic [31:0] dataQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  i2cagg_top dut_i (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbAddr(apbAddr), .apbWdata(apbWdata),
    .apbRdata(apbRdata), .apbReady(apbReady), .apbSlvErr(apbSlvErr), .irqOut(irqOut)
  );

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: mid-cycle sample of each read access phase, popped from scoreboard
  always @(negedge clk) begin
    if (apbSel && apbEnable && !apbWrite) begin
      int a; logic [31:0] e; string t;
      total++;
      if (addrQ.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty at addr %h actual %h expected none", apbAddr, apbRdata);
      end else begin
        a = addrQ.pop_front(); e = dataQ.pop_front(); t = tagQ.pop_front();
        if (apbRdata !== e || a != int'(apbAddr)) begin
          bad++;
          $display("FAIL %s addr %h actual %h expected %h", t, apbAddr, apbRdata, e);
        end
      end
      total++;
      if (apbReady !== 1'b1 || apbSlvErr !== 1'b0) begin // R11
        bad++;
        $display("FAIL R11 ready/err actual %b/%b expected 1/0", apbReady, apbSlvErr);
      end
    end
  end

  task automatic apbWr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    apbSel = 1'b1; apbEnable = 1'b0; apbWrite = 1'b1; apbAddr = a; apbWdata = d;
    @(posedge clk); #2; apbEnable = 1'b1;
    @(posedge clk); #2; apbSel = 1'b0; apbEnable = 1'b0;
  endtask

  task automatic apbRd(input logic [11:0] a, input logic [31:0] e, input string t);
    addrQ.push_back(int'(a)); dataQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); #2;
    apbSel = 1'b1; apbEnable = 1'b0; apbWrite = 1'b0; apbAddr = a;
    @(posedge clk); #2; apbEnable = 1'b1;
    @(posedge clk); #2; apbSel = 1'b0; apbEnable = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s irqOut actual %b expected %b", t, irqOut, e);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #2; rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2; rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual hung expected done");
    finishRun();
  end

  initial begin
    doReset();
    checkIrq(1'b0, "R1 reset line");
    apbRd(12'h000, 32'h0, "R1 global after reset");
    apbRd(12'h04C, 32'h0, "R1 ch0 enable after reset");
    apbRd(12'h4A0, 32'h0, "R1 ch13 buffer after reset");

    apbWr(12'h060, 32'hFFFF_FFA5);
    apbRd(12'h060, 32'h0000_00A5, "R2 R12 ch0 buffer");
    apbWr(12'h1E0, 32'h3C);
    apbRd(12'h1E0, 32'h3C, "R2 ch6 buffer");
    apbWr(12'h320, 32'h77);
    apbRd(12'h320, 32'h77, "R3 ch7 buffer");
    apbWr(12'h4A0, 32'h11);
    apbRd(12'h4A0, 32'h11, "R3 ch13 buffer");

    apbWr(12'h200, 32'hDEAD_BEEF);
    apbRd(12'h200, 32'h0, "R10 low pool write ignored");
    apbRd(12'h2E0, 32'h0, "R3 R10 hole not a channel");
    apbRd(12'h800, 32'h0, "R10 high pool");
    apbRd(12'hFFC, 32'h0, "R10 high pool top");

    apbRd(12'h008, 32'hFFFF_FFFF, "R9 global other offset");
    apbRd(12'h4C0, 32'hFFFF_FFFF, "R9 gap after ch13");
    apbRd(12'h7FC, 32'hFFFF_FFFF, "R9 gap end");
    apbRd(12'h044, 32'hFFFF_FFFF, "R9 channel unused offset");

    apbWr(12'h0CC, 32'h3);
    apbWr(12'h0D4, 32'h6);
    checkIrq(1'b1, "R5 R6 ch2 raise");
    apbRd(12'h0D0, 32'h2, "R5 ch2 masked status");
    apbRd(12'h000, 32'h4, "R4 global bit2");
    apbRd(12'h0D4, 32'h6, "R12 ch2 command");

    apbWr(12'h394, 32'h1);
    apbRd(12'h390, 32'h0, "R5 ch9 masked off");
    apbRd(12'h000, 32'h4, "R5 no pend when masked");
    apbWr(12'h38C, 32'hFFFF);
    apbRd(12'h38C, 32'h7FFF, "R12 enable width");
    apbWr(12'h394, 32'h10);
    apbRd(12'h000, 32'h204, "R4 R5 two pending");

    apbWr(12'h000, 32'h0);
    apbWr(12'h03C, 32'hFFFF_FFFF);
    apbRd(12'h000, 32'h204, "R8 global write ignored");
    checkIrq(1'b1, "R8 line after global write");

    apbWr(12'h0D0, 32'h2);
    checkIrq(1'b1, "R6 R7 other channel still pending");
    apbRd(12'h000, 32'h200, "R7 only ch2 cleared");
    apbRd(12'h0D0, 32'h0, "R7 ch2 status cleared");

    apbWr(12'h390, 32'h0);
    checkIrq(1'b0, "R6 R7 last ack drops line");
    apbRd(12'h000, 32'h0, "R7 ch9 global cleared");
    apbRd(12'h390, 32'h10, "R7 zero write keeps status");

    doReset();
    apbRd(12'h390, 32'h0, "R1 status after reset");
    apbRd(12'h394, 32'h0, "R1 command after reset");
    apbRd(12'h060, 32'h0, "R1 buffer after reset");
    apbRd(12'h38C, 32'h0, "R1 enable after reset");

    repeat (3) @(posedge clk);
    total++;
    if (addrQ.size() != 0) begin
      bad++;
      $display("FAIL R11 pending reads actual %0d expected 0", addrQ.size());
    end
    finishRun();
  end
endmodule